// File: doc/BRIEF.md
# Four-Bit Universal Shift Register

A small register of `WIDTH` bits (four by default) that does one of four things on each rising clock edge, chosen by a two-bit mode input: it keeps its contents, shifts its contents one place toward the least significant bit, shifts one place toward the most significant bit, or loads a parallel word. Each shift direction has its own serial input at the end where new data enters. An active-low clear empties the register at once, without waiting for a clock edge.

The block is used wherever a word must be moved bit by bit, for example for serialising data or deserialising it. Two copies can be chained: a sender loads a word and shifts it out of its least significant bit, and a receiver takes that bit stream into its most significant end. After `WIDTH` shifts the receiver holds the word in parallel.

Top module: `ushift_reg`

## Requirements
- R1: While `rst_ni` is low, `q_o` is all zeros, and it goes to zero when `rst_ni` falls, without waiting for a clock edge.
- R2: While `rst_ni` is low, rising clock edges leave `q_o` at zero whatever the mode, serial and parallel inputs are, including the load mode.
- R3: Mode `2'b00` (hold): at a rising edge `q_o` keeps its value, whatever the serial and parallel inputs are.
- R4: Mode `2'b11` (load): at a rising edge `q_o` takes the value of `par_i`.
- R5: Mode `2'b10` (shift toward the LSB): at a rising edge bit i takes the old bit i+1, bit `WIDTH-1` takes `ser_msb_i`, and the old bit 0 is lost.
- R6: Mode `2'b01` (shift toward the MSB): at a rising edge bit i takes the old bit i-1, bit 0 takes `ser_lsb_i`, and the old bit `WIDTH-1` is lost.
- R7: `q_o` changes only at a rising clock edge or when the clear is asserted. Changes on the mode, serial or parallel inputs between edges do not change `q_o`.
- R8: Two instances chained, with the receiver's `ser_msb_i` taken from the sender's `q_o[0]`: after one load of the sender and then `WIDTH` edges with both in mode `2'b10`, the receiver's `q_o` equals the loaded word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous clear, active low |
| mode_i | input | 2 | Operation: 00 hold, 01 shift toward MSB, 10 shift toward LSB, 11 load |
| ser_msb_i | input | 1 | Serial bit that enters bit WIDTH-1 in mode 10 |
| ser_lsb_i | input | 1 | Serial bit that enters bit 0 in mode 01 |
| par_i | input | WIDTH | Parallel word loaded in mode 11 |
| q_o | output | WIDTH | Register contents |

## Verification
Every mode result is due at the first rising edge after the inputs are set. The bench drives inputs on the falling edge and compares `q_o` on the following falling edge, one edge later. The clear acts at once, so its result is sampled 1 ns after `rst_ni` falls and before any rising edge. The chained transfer is due after one load edge and four shift edges, and the receiver is compared on the falling edge after the fourth shift. The no-change-between-edges checks sample `q_o` after a mid-cycle input change and before the next rising edge.

// File: rtl/ushift_pkg.sv
package ushift_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,  // bits move toward MSB, serial enters bit 0
    MODE_DOWN = 2'b10,  // bits move toward LSB, serial enters top bit
    MODE_LOAD = 2'b11
  } mode_e;
endpackage

// File: rtl/ushift_mux.sv
module ushift_mux
  import ushift_pkg::*;
(
  input  mode_e mode_i,
  input  logic  keep_i,
  input  logic  from_lo_i,
  input  logic  from_hi_i,
  input  logic  par_i,
  output logic  d_o
);
  always_comb begin
    unique case (mode_i)
      MODE_HOLD: d_o = keep_i;
      MODE_UP:   d_o = from_lo_i;
      MODE_DOWN: d_o = from_hi_i;
      MODE_LOAD: d_o = par_i;
      default:   d_o = keep_i;
    endcase
  end
endmodule

// File: rtl/ushift_cell.sv
module ushift_cell
  import ushift_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  from_lo_i,
  input  logic  from_hi_i,
  input  logic  par_i,
  output logic  q_o
);
  logic d;

  ushift_mux u_mux (
    .mode_i    (mode_i),
    .keep_i    (q_o),
    .from_lo_i (from_lo_i),
    .from_hi_i (from_hi_i),
    .par_i     (par_i),
    .d_o       (d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d;
  end

  // R4 at bit level
  assert_cell_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LOAD) |=> (q_o == $past(par_i)));
endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
  import ushift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             ser_msb_i,
  input  logic             ser_lsb_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int TOP = WIDTH - 1;

  mode_e            mode;
  logic [WIDTH-1:0] q;

  assign mode = mode_e'(mode_i);
  assign q_o  = q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic lo_src, hi_src;
    if (i == 0) begin : g_lo_end
      assign lo_src = ser_lsb_i;
    end else begin : g_lo_mid
      assign lo_src = q[i-1];
    end
    if (i == TOP) begin : g_hi_end
      assign hi_src = ser_msb_i;
    end else begin : g_hi_mid
      assign hi_src = q[i+1];
    end

    ushift_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (mode),
      .from_lo_i (lo_src),
      .from_hi_i (hi_src),
      .par_i     (par_i[i]),
      .q_o       (q[i])
    );
  end

  // R1, R2: clear holds the register empty at every edge it covers
  always @(posedge clk_i) begin
    if (!rst_ni) assert_clear_empty_R2: assert (q_o == '0);
  end

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_HOLD) |=> $stable(q_o));

  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_LOAD) |=> (q_o == $past(par_i)));

  assert_down_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_DOWN) |=> (q_o == {$past(ser_msb_i), $past(q_o[TOP:1])}));

  assert_up_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_UP) |=> (q_o == {$past(q_o[TOP-1:0]), $past(ser_lsb_i)}));
endmodule

// File: tb/ushift_reg_tb.sv
`timescale 1ns/1ps
module ushift_reg_tb_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         smsb = 1'b0, slsb = 1'b0;
  logic [W-1:0] par = '0;
  logic [W-1:0] q;

  logic [1:0]   s_mode = 2'b00, r_mode = 2'b00;
  logic [W-1:0] s_par = '0;
  logic [W-1:0] s_q, r_q;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ushift_reg #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .ser_msb_i(smsb), .ser_lsb_i(slsb), .par_i(par), .q_o(q));

  ushift_reg #(.WIDTH(W)) snd_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(s_mode),
    .ser_msb_i(1'b0), .ser_lsb_i(1'b0), .par_i(s_par), .q_o(s_q));

  ushift_reg #(.WIDTH(W)) rcv_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(r_mode),
    .ser_msb_i(s_q[0]), .ser_lsb_i(1'b0), .par_i('0), .q_o(r_q));

  // {mode, ser_msb, ser_lsb, par, expected q}
  localparam logic [11:0] VEC [12] = '{
    12'b11_0_0_1010_1010,
    12'b00_1_1_0101_1010,
    12'b10_1_0_0000_1101,
    12'b10_0_1_1111_0110,
    12'b01_0_1_0000_1101,
    12'b01_1_0_1111_1010,
    12'b11_1_1_0011_0011,
    12'b01_0_1_1100_0111,
    12'b10_1_0_0000_1011,
    12'b00_0_0_1111_1011,
    12'b11_0_0_1111_1111,
    12'b10_0_1_0000_0111
  };

  function automatic string req_of(logic [1:0] m);
    case (m)
      2'b00:   return "R3 hold";
      2'b01:   return "R6 shift toward MSB";
      2'b10:   return "R5 shift toward LSB";
      default: return "R4 load";
    endcase
  endfunction

  function automatic logic [W-1:0] model(logic [W-1:0] cur, logic [1:0] m,
                                         logic hi, logic lo, logic [W-1:0] p);
    case (m)
      2'b00:   return cur;
      2'b01:   return {cur[W-2:0], lo};
      2'b10:   return {hi, cur[W-1:1]};
      default: return p;
    endcase
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] exp;
    #1;
    chk("R1 reset state", q, '0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    // vector table, from empty register
    for (int k = 0; k < 12; k++) begin
      mode = VEC[k][11:10]; smsb = VEC[k][9]; slsb = VEC[k][8]; par = VEC[k][7:4];
      @(negedge clk);
      chk(req_of(VEC[k][11:10]), q, VEC[k][3:0]);
    end

    // random stimulus against a bench model
    exp = q;
    for (int k = 0; k < 300; k++) begin
      mode = 2'($urandom); smsb = 1'($urandom); slsb = 1'($urandom); par = W'($urandom);
      exp = model(exp, mode, smsb, slsb, par);
      @(negedge clk);
      chk(req_of(mode), q, exp);
    end

    // R7: inputs changing between edges leave q alone
    mode = 2'b11; par = 4'b0110;
    @(negedge clk);
    chk("R4 load before mid-cycle test", q, 4'b0110);
    #0.5 mode = 2'b11; par = 4'b1001; smsb = 1'b1; slsb = 1'b1;
    #1;
    chk("R7 no change between edges", q, 4'b0110);
    @(negedge clk);
    chk("R7 change lands at edge", q, 4'b1001);

    // R1: clear acts without a clock edge
    mode = 2'b00;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 asynchronous clear", q, '0);
    // R2: clear overrides load and shifts
    mode = 2'b11; par = 4'b1111;
    @(negedge clk);
    chk("R2 clear beats load", q, '0);
    mode = 2'b10; smsb = 1'b1;
    @(negedge clk);
    chk("R2 clear beats shift toward LSB", q, '0);
    mode = 2'b01; slsb = 1'b1;
    @(negedge clk);
    chk("R2 clear beats shift toward MSB", q, '0);
    rst_n = 1'b1;
    mode = 2'b00; smsb = 1'b1; slsb = 1'b1; par = 4'b1111;
    @(negedge clk);
    chk("R3 hold after clear ignores inputs", q, '0);

    // R8: sender to receiver transfer of every word
    for (int n = 0; n < 16; n++) begin
      s_mode = 2'b11; s_par = W'(n); r_mode = 2'b00;
      @(negedge clk);
      s_mode = 2'b10; r_mode = 2'b10;
      for (int b = 0; b < W; b++) @(negedge clk);
      s_mode = 2'b00; r_mode = 2'b00;
      chk("R8 serial transfer", r_q, W'(n));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule